// File: doc/BRIEF.md
# Interleaving Address Range Decoder

This block is a bank of programmable address-range entries placed where one memory request stream fans out to several downstream ports, such as a host bridge or the upstream side of a switch. Each request carries a host physical address. The bank compares that address against every committed entry at once. The lowest-numbered entry that claims the address picks the downstream port. If no entry claims it, the response is a miss.

Each entry holds a base, a size, a way count, a granularity, an upstream way count and an ordered list of target ports. A one-way entry always sends its traffic to the first target in its list. A multi-way entry takes a few address bits as the index into its target list. These index bits sit just above the bits already used by any interleave level upstream, so two stacked levels of two ways each give four-way interleave across the system.

Software programs the entries through a single write port, one field per write. Requests come in and results go out through a valid/ready handshake, with one cycle from acceptance to response.

Top module: `hdm_route_decoder`

## Requirements
- R1: After reset, every entry is uncommitted and no response is pending (rsp_valid=0). Every request then gets a miss.
- R2: A committed entry hits when base <= addr < base+size. Base and size are counted in 256 MiB units, i.e. address bits [ADDR_W-1:28]. An address outside every committed range is a miss. A miss reports rsp_hit=0, rsp_port=0 and rsp_entry=0.
- R3: A one-way entry (way code 0) sends every hitting address to target slot 0.
- R4: A 2-way entry (way code 1) takes index bit [L] and a 4-way entry (way code 2) takes index bits [L+1:L]. Here L = 8 + granularity code + upstream way code. The index selects the target slot, and slot i is held in target-word bits [2i+1:2i].
- R5: The upstream way code shifts the index bits up (0 = 1 way, 1 = 2 ways, 2 = 4 ways). Address bits below L therefore do not change the chosen port.
- R6: When several committed entries claim one address, the lowest-numbered one wins.
- R7: Writes are selected by cfg_field: 0 base, 1 size, 2 control, 3 target word, 4 commit (cfg_wdata[0] sets or clears it). A write to base, size or control clears that entry's commit bit. An uncommitted entry never hits.
- R8: A control write is rejected when its way code is 3, its granularity code is 7, or its upstream code is 3. The rejected write leaves the entry, including its commit bit, unchanged, and cfg_err is high in the cycle after the write. Every other write leaves cfg_err low.
- R9: Bits [27:0] of a base or size write are dropped.
- R10: A request accepted at a clock edge gives rsp_valid at the next edge. While rsp_ready is low, the response holds steady and req_ready stays low. A response that is consumed and a new request can share a cycle.
- R11: The granularity code g (0..6) sets a granularity of 2^(8+g) bytes. Code 4 is 4 KiB and code 5 is 8 KiB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | ENT_W | Entry number for the write |
| cfg_field | input | 3 | Field selector (see R7) |
| cfg_wdata | input | ADDR_W | Write data; control word is {up[6:5], gran[4:2], ways[1:0]} |
| cfg_err | output | 1 | Previous write was rejected |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Host physical address |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_hit | output | 1 | Address claimed by an entry |
| rsp_port | output | PORT_W | Chosen downstream port |
| rsp_entry | output | ENT_W | Number of the winning entry |

## Verification
Several entry shapes are programmed at once: a one-way entry, a 2-way entry at 4 KiB, a 4-way entry at 8 KiB behind a 2-way upstream level, and a wide one-way entry that overlaps the first three. The range edges show the inclusive base and the exclusive limit. The overlap shows that priority goes to the lower-numbered entry. Stepping the index bits through every value shows that each target slot is read. Setting only the bit that the upstream level consumed shows that this bit is skipped. Directed cases cover commit clearing, rejected control words, the low bits dropped on writes, and a stalled response held against a second request.

// File: rtl/hdm_route_pkg.sv
package hdm_route_pkg;
  // Base and size are kept in units of 2^UNIT_LSB bytes (256 MiB)
  localparam int UNIT_LSB  = 28;
  localparam int MAX_WAYS  = 4;
  localparam int WAYSEL_W  = 2;
  localparam int GRAN_LSB  = 8;   // code 0 means 256 bytes
  localparam int GRAN_MAX  = 6;
  localparam int WCODE_MAX = 2;   // 0:1 way, 1:2 ways, 2:4 ways

  typedef enum logic [2:0] {
    FLD_BASE   = 3'd0,
    FLD_SIZE   = 3'd1,
    FLD_CTRL   = 3'd2,
    FLD_TGT    = 3'd3,
    FLD_COMMIT = 3'd4
  } cfg_field_e;
endpackage

// File: rtl/hdm_entry_regs.sv
module hdm_entry_regs
  import hdm_route_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int PORT_W = 2,
  localparam int UNIT_W = ADDR_W - UNIT_LSB,
  localparam int TGT_W  = MAX_WAYS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [2:0]        wr_field,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [UNIT_W-1:0] base_u,
  output logic [UNIT_W-1:0] size_u,
  output logic [1:0]        ways_c,
  output logic [2:0]        gran_c,
  output logic [1:0]        up_c,
  output logic [TGT_W-1:0]  tgt,
  output logic              commit,
  output logic              reject
);
  logic [UNIT_W-1:0] base_n, size_n;
  logic [1:0]        ways_n, up_n;
  logic [2:0]        gran_n;
  logic [TGT_W-1:0]  tgt_n;
  logic              commit_n;
  logic              ctrl_ok;
  logic              unused_data;

  assign ctrl_ok = (wr_data[1:0] <= 2'(WCODE_MAX)) &&
                   (wr_data[4:2] <= 3'(GRAN_MAX)) &&
                   (wr_data[6:5] <= 2'(WCODE_MAX));
  assign reject  = wr_sel && (wr_field == FLD_CTRL) && !ctrl_ok;
  assign unused_data = ^wr_data;

  always_comb begin
    base_n   = base_u;
    size_n   = size_u;
    ways_n   = ways_c;
    gran_n   = gran_c;
    up_n     = up_c;
    tgt_n    = tgt;
    commit_n = commit;
    if (wr_sel) begin
      unique case (wr_field)
        FLD_BASE: begin
          base_n   = wr_data[ADDR_W-1:UNIT_LSB];
          commit_n = 1'b0;
        end
        FLD_SIZE: begin
          size_n   = wr_data[ADDR_W-1:UNIT_LSB];
          commit_n = 1'b0;
        end
        FLD_CTRL: begin
          if (ctrl_ok) begin
            ways_n   = wr_data[1:0];
            gran_n   = wr_data[4:2];
            up_n     = wr_data[6:5];
            commit_n = 1'b0;
          end
        end
        FLD_TGT:    tgt_n    = wr_data[TGT_W-1:0];
        FLD_COMMIT: commit_n = wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_u <= '0;
      size_u <= '0;
      ways_c <= '0;
      gran_c <= '0;
      up_c   <= '0;
      tgt    <= '0;
      commit <= 1'b0;
    end else if (wr_sel) begin
      base_u <= base_n;
      size_u <= size_n;
      ways_c <= ways_n;
      gran_c <= gran_n;
      up_c   <= up_n;
      tgt    <= tgt_n;
      commit <= commit_n;
    end
  end
endmodule

// File: rtl/hdm_entry_match.sv
module hdm_entry_match
  import hdm_route_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int PORT_W = 2,
  localparam int UNIT_W = ADDR_W - UNIT_LSB,
  localparam int TGT_W  = MAX_WAYS * PORT_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [UNIT_W-1:0] base_u,
  input  logic [UNIT_W-1:0] size_u,
  input  logic [1:0]        ways_c,
  input  logic [2:0]        gran_c,
  input  logic [1:0]        up_c,
  input  logic [TGT_W-1:0]  tgt,
  input  logic              commit,
  output logic              hit,
  output logic [PORT_W-1:0] port
);
  logic [UNIT_W-1:0]   addr_u;
  logic [UNIT_W-1:0]   off_u;
  logic [4:0]          sel_lsb;
  logic [UNIT_LSB-1:0] low_shift;
  logic [WAYSEL_W-1:0] way_mask;
  logic [WAYSEL_W-1:0] slot;

  // Base is unit-aligned, so the offset's low bits equal the address's low bits
  assign addr_u    = addr[ADDR_W-1:UNIT_LSB];
  assign off_u     = addr_u - base_u;
  assign hit       = commit && (addr_u >= base_u) && (off_u < size_u);
  assign sel_lsb   = 5'(GRAN_LSB) + 5'(gran_c) + 5'(up_c);
  assign low_shift = addr[UNIT_LSB-1:0] >> sel_lsb;

  always_comb begin
    unique case (ways_c)
      2'd1:    way_mask = 2'b01;
      2'd2:    way_mask = 2'b11;
      default: way_mask = 2'b00;
    endcase
  end

  assign slot = low_shift[WAYSEL_W-1:0] & way_mask;
  assign port = tgt[slot*PORT_W +: PORT_W];
endmodule

// File: rtl/hdm_pick_first.sv
module hdm_pick_first #(
  parameter int N_ENTRIES = 8,
  parameter int PORT_W    = 2,
  localparam int ENT_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0]        hits,
  input  logic [N_ENTRIES*PORT_W-1:0] ports,
  output logic                        any_hit,
  output logic [ENT_W-1:0]            win_ent,
  output logic [PORT_W-1:0]           win_port
);
  always_comb begin
    any_hit  = 1'b0;
    win_ent  = '0;
    win_port = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit  = 1'b1;
        win_ent  = ENT_W'(i);
        win_port = ports[i*PORT_W +: PORT_W];
      end
    end
  end
endmodule

// File: rtl/hdm_route_decoder.sv
module hdm_route_decoder
  import hdm_route_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int PORT_W    = 2,
  parameter int N_ENTRIES = 8,
  localparam int ENT_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int UNIT_W   = ADDR_W - UNIT_LSB,
  localparam int TGT_W    = MAX_WAYS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ENT_W-1:0]  cfg_idx,
  input  logic [2:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PORT_W-1:0] rsp_port,
  output logic [ENT_W-1:0]  rsp_entry
);
  // Reset: asserted at once, released through two flops
  logic rst_s1, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ok <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ok <= rst_s1;
    end
  end

  logic [N_ENTRIES-1:0]        hits;
  logic [N_ENTRIES-1:0]        rejects;
  logic [N_ENTRIES*PORT_W-1:0] ports;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    logic [UNIT_W-1:0] base_u, size_u;
    logic [1:0]        ways_c, up_c;
    logic [2:0]        gran_c;
    logic [TGT_W-1:0]  tgt;
    logic              commit;
    logic              wr_sel;

    assign wr_sel = rst_ok && cfg_we && (cfg_idx == ENT_W'(e));

    hdm_entry_regs #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_ok),
      .wr_sel   (wr_sel),
      .wr_field (cfg_field),
      .wr_data  (cfg_wdata),
      .base_u   (base_u),
      .size_u   (size_u),
      .ways_c   (ways_c),
      .gran_c   (gran_c),
      .up_c     (up_c),
      .tgt      (tgt),
      .commit   (commit),
      .reject   (rejects[e])
    );

    hdm_entry_match #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_match (
      .addr   (req_addr),
      .base_u (base_u),
      .size_u (size_u),
      .ways_c (ways_c),
      .gran_c (gran_c),
      .up_c   (up_c),
      .tgt    (tgt),
      .commit (commit),
      .hit    (hits[e]),
      .port   (ports[e*PORT_W +: PORT_W])
    );
  end

  logic              any_hit;
  logic [ENT_W-1:0]  win_ent;
  logic [PORT_W-1:0] win_port;

  hdm_pick_first #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_pick (
    .hits     (hits),
    .ports    (ports),
    .any_hit  (any_hit),
    .win_ent  (win_ent),
    .win_port (win_port)
  );

  // Response stage
  logic              accept, rsp_load;
  logic              valid_n, hit_n;
  logic [PORT_W-1:0] port_n;
  logic [ENT_W-1:0]  ent_n;
  logic              err_n;

  assign req_ready = rst_ok && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign rsp_load  = accept || (rsp_valid && rsp_ready);

  always_comb begin
    valid_n = accept;
    hit_n   = accept && any_hit;
    port_n  = (accept && any_hit) ? win_port : '0;
    ent_n   = (accept && any_hit) ? win_ent  : '0;
    err_n   = |rejects;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_port  <= '0;
      rsp_entry <= '0;
    end else if (rsp_load) begin
      rsp_valid <= valid_n;
      rsp_hit   <= hit_n;
      rsp_port  <= port_n;
      rsp_entry <= ent_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) cfg_err <= 1'b0;
    else         cfg_err <= err_n;
  end
endmodule

// File: rtl/hdm_route_decoder_chk.sv
module hdm_route_decoder_chk #(
  parameter int PORT_W = 2,
  parameter int ENT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_err,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [PORT_W-1:0] rsp_port,
  input logic [ENT_W-1:0]  rsp_entry
);
  // R10: a stalled response stays put
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_hit, rsp_port, rsp_entry}));

  // R10: one cycle from acceptance to response
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R10: a response only leaves when it was consumed
  a_r10_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rsp_valid) |-> $past(rsp_ready));

  // R10: no acceptance while a response is stalled
  a_r10_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R2: a miss carries no port and no entry
  a_r2_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> (rsp_port == '0) && (rsp_entry == '0));

  // R8: an error flag only follows a write
  a_r8_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we));
endmodule

bind hdm_route_decoder hdm_route_decoder_chk #(.PORT_W(PORT_W), .ENT_W(ENT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_err   (cfg_err),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_port  (rsp_port),
  .rsp_entry (rsp_entry)
);

// File: tb/hdm_route_decoder_tb.sv
module hdm_route_decoder_tb;
  localparam int ADDR_W = 40;
  localparam int PORT_W = 2;
  localparam int N_ENT  = 8;
  localparam int ENT_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [ENT_W-1:0]  cfg_idx;
  logic [2:0]        cfg_field;
  logic [ADDR_W-1:0] cfg_wdata;
  logic              cfg_err;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic              rsp_valid;
  logic              rsp_ready;
  logic              rsp_hit;
  logic [PORT_W-1:0] rsp_port;
  logic [ENT_W-1:0]  rsp_entry;

  int n_checks = 0;
  int n_errors = 0;
  logic last_err;

  always #2 clk = ~clk;

  hdm_route_decoder #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .N_ENTRIES(N_ENT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .cfg_err(cfg_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_port(rsp_port), .rsp_entry(rsp_entry)
  );

  // {addr, hit, port, entry}
  localparam logic [45:0] VECS [0:14] = '{
    {40'h01_0000_0000, 1'b1, 2'd2, 3'd0},  // R2 R3 base edge
    {40'h01_0FFF_FFFF, 1'b1, 2'd2, 3'd0},  // R2 last byte
    {40'h01_1000_0000, 1'b1, 2'd1, 3'd1},  // R4 slot0
    {40'h01_1000_1000, 1'b1, 2'd3, 3'd1},  // R4 R11 bit12 -> slot1
    {40'h01_2FFF_FFFF, 1'b1, 2'd3, 3'd1},  // R4
    {40'h01_3000_0000, 1'b1, 2'd1, 3'd3},  // R6 fallthrough to wide entry
    {40'h01_4000_0000, 1'b1, 2'd3, 3'd2},  // R4 4-way slot0
    {40'h01_4000_4000, 1'b1, 2'd2, 3'd2},  // R5 slot1
    {40'h01_4000_8000, 1'b1, 2'd1, 3'd2},  // R5 slot2
    {40'h01_4000_C000, 1'b1, 2'd0, 3'd2},  // R5 slot3
    {40'h01_4000_2000, 1'b1, 2'd3, 3'd2},  // R5 upstream bit skipped
    {40'h01_8000_0000, 1'b0, 2'd0, 3'd0},  // R2 past limit
    {40'h00_FFFF_FFFF, 1'b0, 2'd0, 3'd0},  // R2 below base
    {40'h01_7FFF_FFFF, 1'b1, 2'd1, 3'd3},  // R6 wide entry last byte
    {40'h02_0000_0100, 1'b0, 2'd0, 3'd0}   // R7 uncommitted entry
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int fld, input logic [ADDR_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = ENT_W'(idx); cfg_field = 3'(fld); cfg_wdata = d;
    @(negedge clk);
    last_err = cfg_err;
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int idx, input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] s,
                      input logic [ADDR_W-1:0] c, input logic [ADDR_W-1:0] t);
    cfg(idx, 0, b);
    cfg(idx, 1, s);
    cfg(idx, 2, c);
    cfg(idx, 3, t);
    cfg(idx, 4, 1);
  endtask

  task automatic send(string req, input logic [ADDR_W-1:0] a,
                      input logic eh, input logic [1:0] ep, input logic [2:0] ee);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {29'd0, rsp_valid, 2'd0}, {29'd0, 1'b1, 2'd0});
    check(req, {26'd0, rsp_hit, rsp_port, rsp_entry}, {26'd0, eh, ep, ee});
  endtask

  initial begin
    #150000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_field = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 cfg_err", {31'd0, cfg_err}, 32'd0);
    send("R1 miss", 40'h01_0000_0000, 1'b0, 2'd0, 3'd0);
    send("R1 miss", 40'h00_0000_0000, 1'b0, 2'd0, 3'd0);

    prog(0, 40'h01_0000_0000, 40'h00_1000_0000, 40'h00, 40'h02);
    prog(1, 40'h01_1000_0000, 40'h00_2000_0000, 40'h11, 40'h0D);
    prog(2, 40'h01_4000_0000, 40'h00_1000_0000, 40'h36, 40'h1B);
    prog(3, 40'h01_0000_0000, 40'h00_8000_0000, 40'h00, 40'h01);
    cfg(4, 0, 40'h02_0000_0000);
    cfg(4, 1, 40'h00_1000_0000);
    cfg(4, 2, 40'h01);
    cfg(4, 3, 40'h04);

    for (int i = 0; i < 15; i++) begin
      send($sformatf("R2-R7 vector %0d", i), VECS[i][45:6], VECS[i][5], VECS[i][4:3], VECS[i][2:0]);
    end

    // R7 commit enables; R11 granularity code 0 = 256 B
    cfg(4, 4, 1);
    send("R11 256B slot1", 40'h02_0000_0100, 1'b1, 2'd1, 3'd4);
    send("R11 256B slot0", 40'h02_0000_0000, 1'b1, 2'd0, 3'd4);
    cfg(4, 0, 40'h02_0000_0000);
    send("R7 base write clears commit", 40'h02_0000_0100, 1'b0, 2'd0, 3'd0);
    cfg(4, 4, 1);
    send("R7 recommit", 40'h02_0000_0100, 1'b1, 2'd1, 3'd4);

    // R8 rejected control words
    cfg(4, 2, 40'h03);
    check("R8 err ways3", {31'd0, last_err}, 32'd1);
    send("R8 entry kept", 40'h02_0000_0100, 1'b1, 2'd1, 3'd4);
    cfg(4, 2, 40'h1D);
    check("R8 err gran7", {31'd0, last_err}, 32'd1);
    cfg(4, 2, 40'h61);
    check("R8 err up3", {31'd0, last_err}, 32'd1);
    send("R8 entry kept", 40'h02_0000_0000, 1'b1, 2'd0, 3'd4);
    cfg(4, 2, 40'h01);
    check("R8 legal no err", {31'd0, last_err}, 32'd0);
    send("R7 ctrl write clears commit", 40'h02_0000_0100, 1'b0, 2'd0, 3'd0);

    // R9 low bits dropped
    cfg(5, 0, 40'h03_0ABC_DEF0);
    cfg(5, 1, 40'h00_1FFF_FFFF);
    cfg(5, 4, 1);
    send("R9 base rounded", 40'h03_0000_0000, 1'b1, 2'd0, 3'd5);
    send("R9 size rounded", 40'h03_0FFF_FFFF, 1'b1, 2'd0, 3'd5);
    send("R9 size rounded", 40'h03_1000_0000, 1'b0, 2'd0, 3'd0);

    // R10 stall and back-to-back
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 40'h01_0000_0000;
    @(negedge clk);
    check("R10 latency", {31'd0, rsp_valid}, 32'd1);
    check("R10 first rsp", {29'd0, rsp_port, rsp_hit}, {29'd0, 2'd2, 1'b1});
    check("R10 ready low", {31'd0, req_ready}, 32'd0);
    req_addr = 40'h01_4000_C000;
    @(negedge clk);
    check("R10 hold", {26'd0, rsp_hit, rsp_port, rsp_entry}, {26'd0, 1'b1, 2'd2, 3'd0});
    check("R10 ready low", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 back-to-back", {26'd0, rsp_hit, rsp_port, rsp_entry}, {26'd0, 1'b1, 2'd0, 3'd2});
    check("R10 valid", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    check("R10 drained", {31'd0, rsp_valid}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule